// File: doc/BRIEF.md
# Bus Parity Control and Reporting Unit

This block sits between a controller's data path and the pins of a parallel SCSI-style bus that carries two byte lanes, each with its own parity line. On the outgoing side it computes one parity bit per lane. Software chooses whether that bit follows the normal odd rule or the inverted even rule. The even rule lets a test deliberately drive bad parity.

On the incoming side the block captures each qualified input byte cycle into a holding latch. When checking is enabled, it tests every lane of that cycle for odd parity. A failing lane sets a sticky error flag. What happens next depends on the role. As initiator, the block can raise the attention line. As target, it halts the operation unless software has turned the halt off. An interrupt output follows the sticky flag only while its enable is set.

For monitoring, the block shows the live level of each incoming parity line. It also shows the odd parity of each byte held in the latch.

Top module: `bus_parity_unit`

## Requirements
- R1: Each bit of `tx_par` is computed from its lane of `tx_data`, where lane k is bits [8k+7:8k]. With `cfg_even_gen`=0 the byte plus its bit holds an odd number of ones. With `cfg_even_gen`=1 the count is even. The output is combinational, with no clock delay.
- R2: A cycle where `rx_strobe`=1 and `cfg_chk_en`=1 at a rising edge counts as a parity error if any lane of `rx_data` plus its `rx_par` bit holds an even number of ones. An error sets `perr_flag` from the next edge on.
- R3: A cycle with `rx_strobe`=0, or with `cfg_chk_en`=0, never counts as an error. This holds whatever `rx_data` and `rx_par` carry.
- R4: `perr_flag` stays set until a cycle with `sts_clr`=1. If an error arrives in that same cycle, the flag stays set.
- R5: `irq` equals `perr_flag` AND `cfg_irq_en`. The flag sets regardless of the enable.
- R6: An error while `role_init`=1 and `cfg_auto_atn`=1 sets `atn` from the next edge on. `atn` holds until a `restart` cycle that brings no new qualifying error.
- R7: An error while `role_init`=0 and `cfg_no_halt`=0 sets `halt` from the next edge on. `halt` holds until a `restart` cycle that brings no new qualifying error. An error never sets `halt` in initiator role, and never sets it when `cfg_no_halt`=1.
- R8: `live_par` always equals `rx_par`, combinationally.
- R9: Each `rx_strobe` cycle loads `rx_data` into the latch, whatever `cfg_chk_en` is, and `rx_latched` shows it from the next edge. `latched_par` bit k is the odd-parity bit of lane k of the latch.
- R10: During and after reset, `perr_flag`, `atn`, `halt` and `irq` are 0 and the latch holds 0, so `latched_par` reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 16 | Outgoing data, two lanes |
| tx_par | output | 2 | Generated parity per lane |
| rx_data | input | 16 | Incoming data, two lanes |
| rx_par | input | 2 | Incoming parity lines |
| rx_strobe | input | 1 | Qualified input byte cycle |
| cfg_chk_en | input | 1 | Enable parity checking |
| cfg_even_gen | input | 1 | Generate even instead of odd parity |
| cfg_auto_atn | input | 1 | Raise attention on error as initiator |
| cfg_no_halt | input | 1 | Suppress target-mode halt |
| cfg_irq_en | input | 1 | Parity interrupt enable |
| role_init | input | 1 | 1 = initiator role, 0 = target role |
| sts_clr | input | 1 | Clear pulse for the sticky flag |
| restart | input | 1 | Clears halt and attention |
| perr_flag | output | 1 | Sticky parity error status |
| irq | output | 1 | Parity interrupt |
| atn | output | 1 | Attention line request |
| halt | output | 1 | Target-mode halt level |
| live_par | output | 2 | Current level of incoming parity lines |
| rx_latched | output | 16 | Contents of the input latch |
| latched_par | output | 2 | Odd parity of each latched lane |

## Verification
`tx_par`, `live_par` and `irq` are combinational. The bench checks them one time unit after it drives an input, with no clock edge in between. `perr_flag`, `atn`, `halt`, `rx_latched` and `latched_par` pass through one register. The bench therefore drives a stimulus at a falling edge, lets one rising edge capture it, and reads the result at the following falling edge. Held levels are checked again after later idle edges, and the clear and restart pulses follow the same one-edge rule.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;
    typedef struct packed {
        logic perr;
        logic atn;
        logic halt;
    } resp_st_t;

    typedef struct packed {
        logic chk_en;
        logic auto_atn;
        logic no_halt;
        logic role_init;
    } resp_cfg_t;
endpackage

// File: rtl/par_lane_odd.sv
module par_lane_odd #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] lane_byte,
    output logic              odd_bit
);
    // Bit that makes the byte plus this bit hold an odd number of ones.
    assign odd_bit = ~(^lane_byte);
endmodule

// File: rtl/par_rx_latch.sv
module par_rx_latch #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    localparam int BUS_W = LANES * LANE_W;

    logic [BUS_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load) data_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;

    a_r9_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dout == $past(din)));
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/par_err_resp.sv
module par_err_resp
    import bus_parity_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lane_bad,
    input  logic      strobe,
    input  resp_cfg_t cfg,
    input  logic      sts_clr,
    input  logic      restart,
    output logic      perr_flag,
    output logic      atn,
    output logic      halt
);
    resp_st_t st_d, st_q;
    logic     err_hit;

    always_comb begin
        err_hit = strobe && cfg.chk_en && lane_bad;
        st_d    = st_q;
        if (sts_clr) st_d.perr = 1'b0;
        if (restart) begin
            st_d.atn  = 1'b0;
            st_d.halt = 1'b0;
        end
        if (err_hit) begin
            st_d.perr = 1'b1;
            if (cfg.role_init && cfg.auto_atn) st_d.atn  = 1'b1;
            if (!cfg.role_init && !cfg.no_halt) st_d.halt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign perr_flag = st_q.perr;
    assign atn       = st_q.atn;
    assign halt      = st_q.halt;

    a_r2_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cfg.chk_en && lane_bad) |=> perr_flag);
    a_r3_idle_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_flag && (!strobe || !cfg.chk_en)) |=> !perr_flag);
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !sts_clr) |=> perr_flag);
    a_r6_atn_set: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cfg.chk_en && lane_bad && cfg.role_init && cfg.auto_atn) |=> atn);
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> halt);
    a_r7_no_halt_init: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && (cfg.role_init || cfg.no_halt)) |=> !halt);
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bus_parity_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*LANE_W-1:0] tx_data,
    output logic [LANES-1:0]        tx_par,
    input  logic [LANES*LANE_W-1:0] rx_data,
    input  logic [LANES-1:0]        rx_par,
    input  logic                    rx_strobe,
    input  logic                    cfg_chk_en,
    input  logic                    cfg_even_gen,
    input  logic                    cfg_auto_atn,
    input  logic                    cfg_no_halt,
    input  logic                    cfg_irq_en,
    input  logic                    role_init,
    input  logic                    sts_clr,
    input  logic                    restart,
    output logic                    perr_flag,
    output logic                    irq,
    output logic                    atn,
    output logic                    halt,
    output logic [LANES-1:0]        live_par,
    output logic [LANES*LANE_W-1:0] rx_latched,
    output logic [LANES-1:0]        latched_par
);
    logic [LANES-1:0] tx_odd, rx_odd, lane_err;
    logic             lane_bad;
    resp_cfg_t        cfg;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        par_lane_odd #(.LANE_W(LANE_W)) u_tx_odd (
            .lane_byte (tx_data[k*LANE_W +: LANE_W]),
            .odd_bit   (tx_odd[k])
        );
        par_lane_odd #(.LANE_W(LANE_W)) u_rx_odd (
            .lane_byte (rx_data[k*LANE_W +: LANE_W]),
            .odd_bit   (rx_odd[k])
        );
        par_lane_odd #(.LANE_W(LANE_W)) u_lat_odd (
            .lane_byte (rx_latched[k*LANE_W +: LANE_W]),
            .odd_bit   (latched_par[k])
        );
        assign tx_par[k]   = tx_odd[k] ^ cfg_even_gen;
        assign lane_err[k] = rx_par[k] != rx_odd[k];
    end

    assign lane_bad      = |lane_err;
    assign cfg.chk_en    = cfg_chk_en;
    assign cfg.auto_atn  = cfg_auto_atn;
    assign cfg.no_halt   = cfg_no_halt;
    assign cfg.role_init = role_init;

    par_rx_latch #(.LANES(LANES), .LANE_W(LANE_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rx_strobe),
        .din   (rx_data),
        .dout  (rx_latched)
    );

    par_err_resp u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_bad  (lane_bad),
        .strobe    (rx_strobe),
        .cfg       (cfg),
        .sts_clr   (sts_clr),
        .restart   (restart),
        .perr_flag (perr_flag),
        .atn       (atn),
        .halt      (halt)
    );

    assign live_par = rx_par;
    assign irq      = perr_flag & cfg_irq_en;

    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (perr_flag && cfg_irq_en));
    a_r8_live_par: assert property (@(posedge clk) disable iff (!rst_n)
        live_par == rx_par);
endmodule

// File: tb/bus_parity_unit_tb.sv
module bus_parity_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_data = '0, rx_data = '0, rx_latched;
    logic [1:0]  tx_par, rx_par = '0, live_par, latched_par;
    logic        rx_strobe = 0, cfg_chk_en = 0, cfg_even_gen = 0, cfg_auto_atn = 0;
    logic        cfg_no_halt = 0, cfg_irq_en = 0, role_init = 0, sts_clr = 0, restart = 0;
    logic        perr_flag, irq, atn, halt;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    bus_parity_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_par(tx_par),
        .rx_data(rx_data), .rx_par(rx_par), .rx_strobe(rx_strobe),
        .cfg_chk_en(cfg_chk_en), .cfg_even_gen(cfg_even_gen),
        .cfg_auto_atn(cfg_auto_atn), .cfg_no_halt(cfg_no_halt),
        .cfg_irq_en(cfg_irq_en), .role_init(role_init), .sts_clr(sts_clr),
        .restart(restart), .perr_flag(perr_flag), .irq(irq), .atn(atn),
        .halt(halt), .live_par(live_par), .rx_latched(rx_latched),
        .latched_par(latched_par));

    function automatic logic oddp(input logic [7:0] b);
        int n = 0;
        for (int j = 0; j < 8; j++) n += int'(b[j]);
        return (n % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, one posedge captures, return at following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rx_cycle(input logic [15:0] d, input logic [1:0] p);
        rx_data = d; rx_par = p; rx_strobe = 1;
        step();
        rx_strobe = 0;
    endtask

    task automatic pulse_clr();
        sts_clr = 1; step(); sts_clr = 0;
    endtask

    task automatic pulse_restart();
        restart = 1; step(); restart = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [1:0]  p;
        logic        bad;
        repeat (3) @(negedge clk);
        // R10 during reset
        chk({perr_flag, atn, halt, irq} == 4'b0, "R10 in reset", {perr_flag, atn, halt, irq}, 0);
        rst_n = 1;
        step();
        chk({perr_flag, atn, halt, irq} == 4'b0, "R10 after reset", {perr_flag, atn, halt, irq}, 0);
        chk(latched_par == 2'b11 && rx_latched == 0, "R10 latch", {rx_latched, latched_par}, 32'h3);

        // R1 sweep
        for (int e = 0; e < 2; e++) begin
            cfg_even_gen = e[0];
            for (int i = 0; i < 256; i++) begin
                tx_data = {8'(i * 37 + 5), 8'(i)};
                #1;
                p = {oddp(tx_data[15:8]) ^ e[0], oddp(tx_data[7:0]) ^ e[0]};
                chk(tx_par == p, "R1 tx parity", tx_par, p);
            end
        end
        @(negedge clk);

        // R2/R9/R8 sweep: target, no halt
        cfg_chk_en = 1; cfg_no_halt = 1; role_init = 0;
        for (int i = 0; i < 256; i++) begin
            pulse_clr();
            d = {8'(i * 7 + 3), 8'(i)};
            p = {oddp(d[15:8]) ^ i[3], oddp(d[7:0]) ^ i[1]};
            bad = i[3] | i[1];
            rx_data = d; rx_par = p; #1;
            chk(live_par == p, "R8 live parity", live_par, p);
            rx_strobe = 1;
            step();
            rx_strobe = 0;
            chk(perr_flag == bad, "R2 error detect", perr_flag, bad);
            chk(rx_latched == d, "R9 latch data", rx_latched, d);
            chk(latched_par == {oddp(d[15:8]), oddp(d[7:0])}, "R9 latched parity",
                latched_par, {oddp(d[15:8]), oddp(d[7:0])});
            chk(halt == 0, "R7 no_halt suppresses", halt, 0);
        end
        pulse_clr();
        chk(perr_flag == 0, "R4 clear", perr_flag, 0);

        // R3: bad parity without strobe, and with checking off
        rx_data = 16'h0101; rx_par = 2'b11; // both lanes even count -> bad
        step(); step();
        chk(perr_flag == 0, "R3 no strobe", perr_flag, 0);
        cfg_chk_en = 0;
        rx_cycle(16'h0300, 2'b00);
        chk(perr_flag == 0, "R3 check disabled", perr_flag, 0);
        chk(rx_latched == 16'h0300, "R9 latch with check off", rx_latched, 16'h0300);
        cfg_chk_en = 1;

        // R5: flag sets while irq disabled; irq follows enable
        rx_cycle(16'h0000, 2'b01);
        chk(perr_flag == 1 && irq == 0, "R5 flag without irq", {perr_flag, irq}, 2'b10);
        cfg_irq_en = 1; #1;
        chk(irq == 1, "R5 irq enabled", irq, 1);
        step();
        chk(perr_flag == 1, "R4 sticky hold", perr_flag, 1);

        // R4: clear and error in same cycle -> stays set
        rx_data = 16'h0000; rx_par = 2'b10; rx_strobe = 1; sts_clr = 1;
        step();
        rx_strobe = 0; sts_clr = 0;
        chk(perr_flag == 1, "R4 error wins over clear", perr_flag, 1);
        pulse_clr();
        chk(perr_flag == 0 && irq == 0, "R4 cleared", {perr_flag, irq}, 0);

        // R7: target halt
        cfg_no_halt = 0; role_init = 0;
        rx_cycle(16'h0000, 2'b00);
        chk(halt == 1, "R7 target halt", halt, 1);
        chk(atn == 0, "R6 no atn as target", atn, 0);
        step(); step();
        chk(halt == 1, "R7 halt held", halt, 1);
        pulse_restart();
        chk(halt == 0, "R7 restart clears", halt, 0);

        // R6/R7: initiator
        role_init = 1; cfg_auto_atn = 0;
        rx_cycle(16'h0000, 2'b00);
        chk(atn == 0 && halt == 0, "R6 auto off", {atn, halt}, 0);
        cfg_auto_atn = 1;
        rx_cycle(16'h0000, 2'b00);
        chk(atn == 1 && halt == 0, "R6 initiator atn", {atn, halt}, 2'b10);
        step();
        chk(atn == 1, "R6 atn held", atn, 1);
        pulse_restart();
        chk(atn == 0, "R6 restart clears", atn, 0);
        rx_cycle(16'h0000, 2'b11);
        chk(atn == 0, "R6 good parity no atn", atn, 0);

        // R10: reset mid-run
        rx_cycle(16'h0000, 2'b00);
        rst_n = 0; #1;
        chk({perr_flag, atn, halt, irq} == 4'b0, "R10 async reset", {perr_flag, atn, halt, irq}, 0);
        chk(latched_par == 2'b11, "R10 latch reset", latched_par, 2'b11);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule